// File: doc/BRIEF.md
# Time-Multiplexed Torus Routing Switch

This block is the routing switch of one tile in a two-dimensional torus in which traffic only moves one way. Words arrive from the west neighbour, from the north neighbour and from the tile's own processing element. Words leave toward the east neighbour, toward the south neighbour and into the processing element. Every link is made of `CHAN` parallel channels. Each channel carries a data word and a valid bit. The array edges wrap around, so every tile has the same four neighbour links.

There is no flow control and no arbitration. A compiler fixes all routing in advance as a schedule of `CTX` time slots that repeats forever. A context counter steps through the slots, one slot per cycle. For each output channel, the active slot holds a select code that names one input channel, or that leaves the output idle. The switch registers the chosen word, so it appears one clock after it was presented.

The schedule is written through a simple write port. The port is addressed by slot, output link and channel. Writes take effect only while configure mode is held high. While configure mode is high, traffic is stopped and the counter is held at slot 0, so a run always starts from a known slot.

Top module: `tts_torus_switch`

## Requirements
- R1: During and after an asynchronous reset (`rst_n` low), every output valid bit and data word is 0, the context counter is at slot 0, and every schedule entry holds select code 0. With no writes after reset, all outputs therefore stay invalid.
- R2: Select code mapping, with `C` = `CHAN`. Code 0 means idle. Codes 1..C pick west channel (code-1). Codes C+1..2C pick north channel (code-C-1). Codes 2C+1..3C pick local input channel (code-2C-1). Any code above 3C means idle.
- R3: An output channel takes the data and valid of its selected input as sampled at a rising edge, and presents them from that edge until the next one. The latency is one cycle.
- R4: The context counter advances by one at every edge while configure mode is low, and wraps from `CTX`-1 to 0. The routing applied at an edge is the entry of the slot the counter holds just before that edge.
- R5: When the output is idle, or the selected input's valid is low, the output valid is 0 and the output data is forced to 0.
- R6: A schedule write (`cfg_we` high) changes the stored entry only while `cfg_mode` is high. A write made with `cfg_mode` low has no effect on later routing.
- R7: While `cfg_mode` is high, all outputs are invalid with zero data at the next edge, and the counter is held at slot 0. The first edge after `cfg_mode` falls uses slot 0.
- R8: A write whose link field `cfg_port` is 3 is ignored. The link codes are 0 = east, 1 = south and 2 = local output.
- R9: One input channel may feed any number of output channels in the same slot (broadcast).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | Configure mode: enables writes, halts traffic, holds counter at 0 |
| cfg_we | input | 1 | Schedule write strobe |
| cfg_ctx | input | CTXW | Slot to write |
| cfg_port | input | 2 | Output link to write (0 east, 1 south, 2 local) |
| cfg_chan | input | CHW | Output channel to write |
| cfg_sel | input | SELW | Select code to store |
| west_data | input | CHAN*DW | Data from west neighbour, channel k at bits k*DW |
| west_valid | input | CHAN | Valid bits from west neighbour |
| north_data | input | CHAN*DW | Data from north neighbour |
| north_valid | input | CHAN | Valid bits from north neighbour |
| pe_tx_data | input | CHAN*DW | Data injected by the local processing element |
| pe_tx_valid | input | CHAN | Valid bits from the local processing element |
| east_data | output | CHAN*DW | Registered data toward east neighbour |
| east_valid | output | CHAN | Valid bits toward east neighbour |
| south_data | output | CHAN*DW | Registered data toward south neighbour |
| south_valid | output | CHAN | Valid bits toward south neighbour |
| pe_rx_data | output | CHAN*DW | Registered data delivered to the local processing element |
| pe_rx_valid | output | CHAN | Valid bits delivered to the local processing element |

## Verification
Every routed result is due exactly one rising edge after the inputs that produce it. The bench changes inputs 1 ns after an edge, computes the expected outputs from those inputs and the slot its own counter model predicts, and compares 1 ns after the next edge. Schedule writes and configure-mode changes take effect at the edge that samples them. The bench's slot model therefore resets to 0 after any edge with configure mode high, and advances otherwise, including across the write cycles of the ignored-write test.

// File: rtl/tts_pkg.sv
package tts_pkg;
   // number of output links: east, south, local
   localparam int NLINK = 3;

   typedef enum logic [1:0] {
      LINK_EAST  = 2'd0,
      LINK_SOUTH = 2'd1,
      LINK_LOCAL = 2'd2
   } link_e;

   function automatic int sel_bits(input int chan);
      return $clog2(3 * chan + 1);
   endfunction

   function automatic int idx_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/tts_ctx_seq.sv
module tts_ctx_seq #(
   parameter int CTX  = 4,
   parameter int CTXW = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hold,
   output logic [CTXW-1:0] ctx
);
   localparam logic [CTXW-1:0] LAST = CTXW'(CTX - 1);

   generate
      if (CTX == 1) begin : g_single
         // a one-slot schedule never moves
         assign ctx = '0;
      end else begin : g_count
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ctx <= '0;
            else if (hold)
               ctx <= '0;
            else if (ctx == LAST)
               ctx <= '0;
            else
               ctx <= ctx + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/tts_sel_table.sv
module tts_sel_table #(
   parameter int CHAN  = 4,
   parameter int CTX   = 4,
   parameter int SELW  = 4,
   parameter int CTXW  = 2,
   parameter int CHW   = 2,
   parameter int NLINK = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [CTXW-1:0]             wctx,
   input  logic [1:0]                  wport,
   input  logic [CHW-1:0]              wchan,
   input  logic [SELW-1:0]             wsel,
   input  logic [CTXW-1:0]             rctx,
   output logic [NLINK*CHAN*SELW-1:0]  rsel
);
   localparam int ROWW = NLINK * CHAN * SELW;

   logic [ROWW-1:0] tbl [CTX];

   // Each field matches only an in-range address, so out-of-range
   // writes (e.g. link code 3) fall through untouched.
   generate
      for (genvar c = 0; c < CTX; c++) begin : g_slot
         for (genvar p = 0; p < NLINK; p++) begin : g_link
            for (genvar ch = 0; ch < CHAN; ch++) begin : g_ch
               localparam int LO = (p * CHAN + ch) * SELW;
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n)
                     tbl[c][LO +: SELW] <= '0;
                  else if (we && wctx == CTXW'(c) &&
                           wport == 2'(p) && wchan == CHW'(ch))
                     tbl[c][LO +: SELW] <= wsel;
               end
            end
         end
      end
   endgenerate

   always_comb begin
      rsel = '0;
      for (int c = 0; c < CTX; c++)
         if (rctx == CTXW'(c))
            rsel = tbl[c];
   end
endmodule

// File: rtl/tts_port_xbar.sv
module tts_port_xbar #(
   parameter int CHAN = 4,
   parameter int DW   = 32,
   parameter int SELW = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   force_idle,
   input  logic [3*CHAN*DW-1:0]   src_data,
   input  logic [3*CHAN-1:0]      src_valid,
   input  logic [CHAN*SELW-1:0]   sel,
   output logic [CHAN*DW-1:0]     out_data,
   output logic [CHAN-1:0]        out_valid
);
   localparam int NSRC = 3 * CHAN;

   generate
      for (genvar o = 0; o < CHAN; o++) begin : g_out
         logic [SELW-1:0] code;
         logic            nxt_v;
         logic [DW-1:0]   nxt_d;

         assign code = sel[o*SELW +: SELW];

         always_comb begin
            nxt_v = 1'b0;
            nxt_d = '0;
            for (int k = 0; k < NSRC; k++) begin
               if (code == SELW'(k + 1)) begin
                  nxt_v = src_valid[k];
                  nxt_d = src_data[k*DW +: DW];
               end
            end
            if (force_idle || !nxt_v) begin
               nxt_v = 1'b0;
               nxt_d = '0;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid[o]           <= 1'b0;
               out_data[o*DW +: DW]   <= '0;
            end else begin
               out_valid[o]           <= nxt_v;
               out_data[o*DW +: DW]   <= nxt_d;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/tts_torus_switch.sv
module tts_torus_switch
   import tts_pkg::*;
#(
   parameter int CHAN = 4,
   parameter int DW   = 32,
   parameter int CTX  = 4,
   localparam int SELW = sel_bits(CHAN),
   localparam int CTXW = idx_bits(CTX),
   localparam int CHW  = idx_bits(CHAN)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_mode,
   input  logic                cfg_we,
   input  logic [CTXW-1:0]     cfg_ctx,
   input  logic [1:0]          cfg_port,
   input  logic [CHW-1:0]      cfg_chan,
   input  logic [SELW-1:0]     cfg_sel,
   input  logic [CHAN*DW-1:0]  west_data,
   input  logic [CHAN-1:0]     west_valid,
   input  logic [CHAN*DW-1:0]  north_data,
   input  logic [CHAN-1:0]     north_valid,
   input  logic [CHAN*DW-1:0]  pe_tx_data,
   input  logic [CHAN-1:0]     pe_tx_valid,
   output logic [CHAN*DW-1:0]  east_data,
   output logic [CHAN-1:0]     east_valid,
   output logic [CHAN*DW-1:0]  south_data,
   output logic [CHAN-1:0]     south_valid,
   output logic [CHAN*DW-1:0]  pe_rx_data,
   output logic [CHAN-1:0]     pe_rx_valid
);
   // elaboration-time parameter checks
   generate
      if (CHAN < 1) begin : g_bad_chan
         $error("tts_torus_switch: CHAN must be at least 1");
      end
      if (DW < 1) begin : g_bad_dw
         $error("tts_torus_switch: DW must be at least 1");
      end
      if (CTX < 1) begin : g_bad_ctx
         $error("tts_torus_switch: CTX must be at least 1");
      end
   endgenerate

   logic [CTXW-1:0]             ctx;
   logic [NLINK*CHAN*SELW-1:0]  cur_sel;
   logic [3*CHAN*DW-1:0]        src_data;
   logic [3*CHAN-1:0]           src_valid;
   logic [CHAN*DW-1:0]          link_d [NLINK];
   logic [CHAN-1:0]             link_v [NLINK];

   // source order: west lowest, then north, then local
   assign src_data  = {pe_tx_data, north_data, west_data};
   assign src_valid = {pe_tx_valid, north_valid, west_valid};

   tts_ctx_seq #(.CTX(CTX), .CTXW(CTXW)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (cfg_mode),
      .ctx   (ctx)
   );

   tts_sel_table #(
      .CHAN(CHAN), .CTX(CTX), .SELW(SELW),
      .CTXW(CTXW), .CHW(CHW), .NLINK(NLINK)
   ) u_tab (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we & cfg_mode),
      .wctx  (cfg_ctx),
      .wport (cfg_port),
      .wchan (cfg_chan),
      .wsel  (cfg_sel),
      .rctx  (ctx),
      .rsel  (cur_sel)
   );

   generate
      for (genvar p = 0; p < NLINK; p++) begin : g_link
         tts_port_xbar #(.CHAN(CHAN), .DW(DW), .SELW(SELW)) u_xbar (
            .clk        (clk),
            .rst_n      (rst_n),
            .force_idle (cfg_mode),
            .src_data   (src_data),
            .src_valid  (src_valid),
            .sel        (cur_sel[p*CHAN*SELW +: CHAN*SELW]),
            .out_data   (link_d[p]),
            .out_valid  (link_v[p])
         );
      end
   endgenerate

   assign east_data   = link_d[LINK_EAST];
   assign east_valid  = link_v[LINK_EAST];
   assign south_data  = link_d[LINK_SOUTH];
   assign south_valid = link_v[LINK_SOUTH];
   assign pe_rx_data  = link_d[LINK_LOCAL];
   assign pe_rx_valid = link_v[LINK_LOCAL];
endmodule

// File: rtl/tts_sva.sv
module tts_sva #(
   parameter int CHAN = 4,
   parameter int CTX  = 4,
   parameter int CTXW = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cfg_mode,
   input logic [CTXW-1:0] ctx,
   input logic [CHAN-1:0] west_valid,
   input logic [CHAN-1:0] north_valid,
   input logic [CHAN-1:0] pe_tx_valid,
   input logic [CHAN-1:0] east_valid,
   input logic [CHAN-1:0] south_valid,
   input logic [CHAN-1:0] pe_rx_valid
);
   localparam logic [CTXW:0]   NSLOT = (CTXW + 1)'(CTX);
   localparam logic [CTXW-1:0] LAST  = CTXW'(CTX - 1);

   logic any_in, any_out;
   assign any_in  = |{west_valid, north_valid, pe_tx_valid};
   assign any_out = |{east_valid, south_valid, pe_rx_valid};

   assert_ctx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, ctx} < NSLOT);

   assert_ctx_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_mode && ctx == LAST) |=> ctx == '0);

   assert_ctx_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_mode && ctx != LAST) |=> ctx == $past(ctx) + 1'b1);

   assert_cfg_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_mode |=> (ctx == '0 && !any_out));

   assert_no_phantom_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !any_in |=> !any_out);
endmodule

bind tts_torus_switch tts_sva #(.CHAN(CHAN), .CTX(CTX), .CTXW(CTXW)) u_sva (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_mode    (cfg_mode),
   .ctx         (ctx),
   .west_valid  (west_valid),
   .north_valid (north_valid),
   .pe_tx_valid (pe_tx_valid),
   .east_valid  (east_valid),
   .south_valid (south_valid),
   .pe_rx_valid (pe_rx_valid)
);

// File: tb/sim_tts_torus_switch.sv
`timescale 1ns/1ps
module sim_tts_torus_switch;
   localparam int C    = 4;
   localparam int DW   = 32;
   localparam int II   = 4;
   localparam int SELW = 4;
   localparam int CTXW = 2;
   localparam int CHW  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_mode = 1'b0, cfg_we = 1'b0;
   logic [CTXW-1:0] cfg_ctx = '0;
   logic [1:0]      cfg_port = '0;
   logic [CHW-1:0]  cfg_chan = '0;
   logic [SELW-1:0] cfg_sel = '0;
   logic [C*DW-1:0] west_data = '0, north_data = '0, pe_tx_data = '0;
   logic [C-1:0]    west_valid = '0, north_valid = '0, pe_tx_valid = '0;
   logic [C*DW-1:0] east_data, south_data, pe_rx_data;
   logic [C-1:0]    east_valid, south_valid, pe_rx_valid;

   always #2.5 clk = ~clk;

   tts_torus_switch #(.CHAN(C), .DW(DW), .CTX(II)) u0 (.*);

   int n_chk = 0, n_bad = 0, mctx = 0;
   int mtab [II][3][C];
   bit done = 0;

   function automatic logic [DW:0] predict(input int code);
      int k;
      logic v;
      logic [DW-1:0] d;
      if (cfg_mode || code < 1 || code > 3*C) return '0;
      k = code - 1;
      case (k / C)
         0: begin v = west_valid[k%C];  d = west_data[(k%C)*DW +: DW];  end
         1: begin v = north_valid[k%C]; d = north_data[(k%C)*DW +: DW]; end
         default: begin v = pe_tx_valid[k%C]; d = pe_tx_data[(k%C)*DW +: DW]; end
      endcase
      return v ? {1'b1, d} : '0;
   endfunction

   function automatic logic [DW:0] observe(input int p, input int ch);
      case (p)
         0: return {east_valid[ch],  east_data[ch*DW +: DW]};
         1: return {south_valid[ch], south_data[ch*DW +: DW]};
         default: return {pe_rx_valid[ch], pe_rx_data[ch*DW +: DW]};
      endcase
   endfunction

   task automatic check(input string tag, input int p, input int ch, input logic [DW:0] exp);
      logic [DW:0] got;
      got = observe(p, ch);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s link %0d ch %0d: got v=%b d=%h exp v=%b d=%h",
                  tag, p, ch, got[DW], got[DW-1:0], exp[DW], exp[DW-1:0]);
      end
   endtask

   task automatic randomize_inputs();
      for (int ch = 0; ch < C; ch++) begin
         west_data[ch*DW +: DW]  = $urandom;
         north_data[ch*DW +: DW] = $urandom;
         pe_tx_data[ch*DW +: DW] = $urandom;
      end
      west_valid  = C'($urandom);
      north_valid = C'($urandom);
      pe_tx_valid = C'($urandom);
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      mctx = cfg_mode ? 0 : (mctx + 1) % II;
   endtask

   // one routed cycle: predict from current inputs, check one edge later
   task automatic route_step(input string tag);
      logic [DW:0] exp [3][C];
      for (int p = 0; p < 3; p++)
         for (int ch = 0; ch < C; ch++)
            exp[p][ch] = predict(mtab[mctx][p][ch]);
      tick();
      for (int p = 0; p < 3; p++)
         for (int ch = 0; ch < C; ch++)
            check(tag, p, ch, exp[p][ch]);
   endtask

   task automatic cfg_write(input int s, input int p, input int ch, input int code);
      cfg_we = 1'b1; cfg_ctx = CTXW'(s); cfg_port = 2'(p);
      cfg_chan = CHW'(ch); cfg_sel = SELW'(code);
      if (cfg_mode && p < 3) mtab[s][p][ch] = code;
      tick();
      cfg_we = 1'b0;
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      for (int s = 0; s < II; s++)
         for (int p = 0; p < 3; p++)
            for (int ch = 0; ch < C; ch++)
               mtab[s][p][ch] = 0;
      randomize_inputs();
      #12;
      // R1: outputs idle while reset is held
      for (int p = 0; p < 3; p++)
         for (int ch = 0; ch < C; ch++)
            check("R1 reset", p, ch, '0);
      @(posedge clk); #1; rst_n = 1'b1; mctx = 0;
      // R1: empty schedule keeps valid inputs from reaching outputs
      for (int i = 0; i < II + 1; i++) begin randomize_inputs(); route_step("R1 empty table"); end

      // R7: configure mode silences traffic
      cfg_mode = 1'b1;
      randomize_inputs(); route_step("R7 cfg halt");
      // random schedule, codes 0..15 include out-of-range ones (R2)
      for (int s = 0; s < II; s++)
         for (int p = 0; p < 3; p++)
            for (int ch = 0; ch < C; ch++)
               cfg_write(s, p, ch, int'($urandom % 16));
      // R8: link code 3 must be ignored
      for (int ch = 0; ch < C; ch++) cfg_write(ch % II, 3, ch, 1);
      randomize_inputs(); route_step("R7 cfg halt");

      cfg_mode = 1'b0;
      // R2 R3 R4 R5 R8: routed traffic under the random schedule
      for (int i = 0; i < 60; i++) begin randomize_inputs(); route_step("R2 R3 R4 R5 R8"); end

      // directed: every input valid, then every input invalid (R5)
      west_valid = '1; north_valid = '1; pe_tx_valid = '1;
      for (int i = 0; i < II; i++) route_step("R2 all valid");
      west_valid = '0; north_valid = '0; pe_tx_valid = '0;
      for (int i = 0; i < II; i++) route_step("R5 none valid");

      // R6: writes with configure mode low change nothing
      for (int ch = 0; ch < C; ch++) cfg_write(0, 0, ch, (mtab[0][0][ch] + 5) % 13);
      for (int i = 0; i < 2*II; i++) begin randomize_inputs(); route_step("R6 ignored write"); end

      // R7: re-entering configure mode restarts at slot 0 mid-run
      route_step("R7 pre");
      cfg_mode = 1'b1;
      // R9: broadcast local channel 0 to every output of slot 1
      for (int p = 0; p < 3; p++)
         for (int ch = 0; ch < C; ch++)
            cfg_write(1, p, ch, 2*C + 1);
      cfg_write(2, 0, 0, 3*C);        // R2: top code, local last channel
      cfg_write(3, 1, C-1, 3*C + 1);  // R2: first out-of-range code
      cfg_mode = 1'b0;
      for (int i = 0; i < 3*II; i++) begin
         randomize_inputs();
         pe_tx_valid[0] = 1'b1;
         route_step("R9 R7 broadcast");
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got hung run exp completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule